// File: doc/BRIEF.md
# Parallel Multi-Register Move Engine

This block runs three multi-register move operations against a 256-entry register file that lives outside it. A 64-bit instruction word arrives on a valid/ready handshake. The block decodes it as one of three forms: a two-pair swizzle, a gather of four sources into four consecutive registers, or a scatter of four consecutive registers to four listed destinations. It then expands the operation into single-register accesses over one read port and one write port.

The defining property is parallel semantics. Every source value is read into an internal holding buffer before the first destination is written. Overlapping source and destination sets, such as a two-register exchange, therefore give the same result as if all moves happened at once.

A word that does not carry the required fixed pattern is rejected. It produces a one-cycle error pulse and no register write. A legal word ends with a one-cycle done pulse, and the engine accepts the next word on the cycle after that pulse.

Top module: `pme_engine`

## Requirements
- R1: A word is legal only when bits 63:61 are 3'b001, bit 42 is 0 and bits 58:57 are 3'b10's low two bits (2'b10). Bits 44, 45, 46..48, 50..52, 55, 56, 59 and 60 are ignored. An illegal word raises `illegal` for exactly one cycle (the cycle after acceptance), with no write and no `done`.
- R2: Bits 41:40 pick the operation: 2'b00 swizzle, 2'b01 gather, 2'b10 scatter. The value 2'b11 is illegal.
- R3: Swizzle copies the register named by bits 7:0 into the register named by bits 39:32, and the register named by bits 15:8 into the register named by bits 23:16. A swizzle with bits 31:24 non-zero is illegal.
- R4: Gather copies the registers named by bits 7:0, 15:8, 23:16 and 31:24 into registers D, D+1, D+2 and D+3, where D is bits 39:32.
- R5: Scatter copies registers S, S+1, S+2 and S+3, where S is bits 7:0, into the registers named by bits 39:32, 15:8, 23:16 and 31:24 respectively.
- R6: All sources are read before any destination is written, so a swizzle with crossed source and destination pairs exchanges the two registers.
- R7: A word with bit 43 set, bit 49 set, or bits 54:53 not equal to 2'b00 is illegal.
- R8: A legal operation with N moves (N=2 for swizzle, 4 otherwise) performs N read cycles, then N write cycles, then one `done` cycle. `done` is therefore high in cycle 2N+1 after the accepting edge. Reads, writes, `done` and `illegal` are never active together.
- R9: When several moves of one operation target the same register, the writes happen in listed order, so the last listed move decides the final value.
- R10: Register index arithmetic for gather and scatter wraps modulo 256.
- R11: After reset, `insn_ready` is high with no read, write, `done` or `illegal`. `insn_ready` is low from the cycle after acceptance through the `done` or `illegal` cycle, and high again in the cycle after it. Words presented while it is low are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_word | input | 64 | Instruction word |
| insn_ready | output | 1 | Engine idle and able to take a word |
| rf_rd_en | output | 1 | Register read in this cycle |
| rf_rd_addr | output | 8 | Register read index |
| rf_rd_data | input | DATA_W | Read data, same-cycle response to rf_rd_addr |
| rf_wr_en | output | 1 | Register write in this cycle |
| rf_wr_addr | output | 8 | Register write index |
| rf_wr_data | output | DATA_W | Register write data |
| done | output | 1 | One-cycle pulse at the end of a legal operation |
| illegal | output | 1 | One-cycle pulse for a rejected word |

## Verification
A holding buffer that is read or filled in the wrong slot shows up as a wrong register value in the file as soon as the write phase ends, at most nine cycles after acceptance. A sequencer that interleaves writes with reads breaks the exchange and overlapping gather cases in the same window. A wrong slot count or a stuck state shows as `done` arriving on the wrong cycle, or as `insn_ready` not returning one cycle after the pulse. A decoder that accepts a bad pattern shows as register writes, or a missing error pulse, in the cycle right after acceptance.

// File: rtl/pme_pkg.sv
package pme_pkg;

   localparam int REG_W    = 8;
   localparam int SLOTS    = 4;
   localparam int INSN_W   = 64;
   localparam int IDX_W    = $clog2(SLOTS);

   typedef enum logic [1:0] {
      SUB_SWZ = 2'b00,
      SUB_GAT = 2'b01,
      SUB_SCT = 2'b10,
      SUB_BAD = 2'b11
   } pme_sub_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_FIN,
      ST_ERR
   } pme_state_e;

   typedef logic [SLOTS-1:0][REG_W-1:0] pme_regs_t;

endpackage

// File: rtl/pme_decoder.sv
module pme_decoder
   import pme_pkg::*;
(
   input  logic [INSN_W-1:0] word,
   output logic              legal,
   output pme_regs_t         src,
   output pme_regs_t         dst,
   output logic [IDX_W-1:0]  last_idx
);

   pme_sub_e          sub;
   logic [REG_W-1:0]  head_dst;
   logic [REG_W-1:0]  base;
   pme_regs_t         lane;
   pme_regs_t         stride;
   logic              class_ok;
   logic              group_ok;
   logic              flags_ok;
   logic              pad_ok;

   assign sub      = pme_sub_e'(word[41:40]);
   assign head_dst = word[39:32];
   assign base     = (sub == SUB_GAT) ? head_dst : word[7:0];

   assign class_ok = (word[63:61] == 3'b001) && !word[42];
   assign group_ok = (word[58:57] == 2'b10) && (sub != SUB_BAD);
   assign flags_ok = !word[43] && !word[49] && (word[54:53] == 2'b00);
   assign pad_ok   = (sub != SUB_SWZ) || (word[31:24] == 8'h00);
   assign legal    = class_ok && group_ok && flags_ok && pad_ok;

   assign last_idx = (sub == SUB_SWZ) ? IDX_W'(1) : IDX_W'(SLOTS - 1);

   for (genvar k = 0; k < SLOTS; k++) begin : g_lane
      assign lane[k]   = word[REG_W*k +: REG_W];
      assign stride[k] = base + REG_W'(k);

      assign src[k] = (sub == SUB_SCT) ? stride[k] : lane[k];

      if (k == 0) begin : g_head
         assign dst[k] = (sub == SUB_GAT) ? stride[k] : head_dst;
      end else if (k == 1) begin : g_second
         always_comb begin
            unique case (sub)
               SUB_GAT: dst[k] = stride[k];
               SUB_SWZ: dst[k] = lane[2];
               default: dst[k] = lane[k];
            endcase
         end
      end else begin : g_tail
         assign dst[k] = (sub == SUB_GAT) ? stride[k] : lane[k];
      end
   end

endmodule

// File: rtl/pme_hold_buf.sv
module pme_hold_buf
   import pme_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [IDX_W-1:0]  cap_idx,
   input  logic [DATA_W-1:0] cap_data,
   input  logic [IDX_W-1:0]  out_idx,
   output logic [DATA_W-1:0] out_data
);

   logic [SLOTS-1:0][DATA_W-1:0] slot_q;

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[k] <= '0;
         end else if (cap_en && (cap_idx == IDX_W'(k))) begin
            slot_q[k] <= cap_data;
         end
      end
   end

   assign out_data = slot_q[out_idx];

endmodule

// File: rtl/pme_seq.sv
module pme_seq
   import pme_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_legal,
   input  logic [IDX_W-1:0] last_idx,
   output logic             ready,
   output logic             rd_en,
   output logic             wr_en,
   output logic             done,
   output logic             illegal,
   output logic [IDX_W-1:0] idx
);

   pme_state_e       state_q;
   pme_state_e       state_d;
   logic [IDX_W-1:0] idx_d;
   logic             at_last;

   assign at_last = (idx == last_idx);

   always_comb begin
      state_d = state_q;
      idx_d   = idx;
      unique case (state_q)
         ST_IDLE: begin
            idx_d = '0;
            if (start) state_d = start_legal ? ST_READ : ST_ERR;
         end
         ST_READ: begin
            if (at_last) begin
               state_d = ST_WRITE;
               idx_d   = '0;
            end else begin
               idx_d = idx + IDX_W'(1);
            end
         end
         ST_WRITE: begin
            if (at_last) begin
               state_d = ST_FIN;
               idx_d   = '0;
            end else begin
               idx_d = idx + IDX_W'(1);
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx     <= '0;
      end else begin
         state_q <= state_d;
         idx     <= idx_d;
      end
   end

   assign ready   = (state_q == ST_IDLE);
   assign rd_en   = (state_q == ST_READ);
   assign wr_en   = (state_q == ST_WRITE);
   assign done    = (state_q == ST_FIN);
   assign illegal = (state_q == ST_ERR);

endmodule

// File: rtl/pme_engine.sv
module pme_engine
   import pme_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   input  logic [63:0]       insn_word,
   output logic              insn_ready,
   output logic              rf_rd_en,
   output logic [7:0]        rf_rd_addr,
   input  logic [DATA_W-1:0] rf_rd_data,
   output logic              rf_wr_en,
   output logic [7:0]        rf_wr_addr,
   output logic [DATA_W-1:0] rf_wr_data,
   output logic              done,
   output logic              illegal
);

   if (DATA_W < 1) begin : g_bad_width
      $error("pme_engine: DATA_W must be at least 1");
   end
   if (REG_W != 8 || SLOTS != 4 || INSN_W != 64) begin : g_bad_pkg
      $error("pme_engine: field layout needs 8-bit indices, 4 slots, 64-bit words");
   end

   logic             accept;
   logic             dec_legal;
   pme_regs_t        dec_src;
   pme_regs_t        dec_dst;
   logic [IDX_W-1:0] dec_last;
   pme_regs_t        src_q;
   pme_regs_t        dst_q;
   logic [IDX_W-1:0] last_q;
   logic [IDX_W-1:0] idx;

   assign accept = insn_valid && insn_ready;

   pme_decoder u_dec (
      .word     (insn_word),
      .legal    (dec_legal),
      .src      (dec_src),
      .dst      (dec_dst),
      .last_idx (dec_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         last_q <= '0;
      end else if (accept && dec_legal) begin
         src_q  <= dec_src;
         dst_q  <= dec_dst;
         last_q <= dec_last;
      end
   end

   pme_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .start_legal (dec_legal),
      .last_idx    (last_q),
      .ready       (insn_ready),
      .rd_en       (rf_rd_en),
      .wr_en       (rf_wr_en),
      .done        (done),
      .illegal     (illegal),
      .idx         (idx)
   );

   pme_hold_buf #(.DATA_W(DATA_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (rf_rd_en),
      .cap_idx  (idx),
      .cap_data (rf_rd_data),
      .out_idx  (idx),
      .out_data (rf_wr_data)
   );

   assign rf_rd_addr = src_q[idx];
   assign rf_wr_addr = dst_q[idx];

endmodule

// File: rtl/pme_checker.sv
module pme_checker (
   input logic clk,
   input logic rst_n,
   input logic insn_valid,
   input logic insn_ready,
   input logic rf_rd_en,
   input logic rf_wr_en,
   input logic done,
   input logic illegal
);

   // R11: busy in the cycle after a word is taken
   p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_ready) |=> !insn_ready);

   // R11: an idle engine touches no register
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      insn_ready |-> (!rf_rd_en && !rf_wr_en));

   // R1: rejected word writes nothing and is a single pulse
   p_illegal_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!rf_wr_en && !done));
   p_illegal_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> (!illegal && insn_ready));

   // R8: done is one cycle, followed by idle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && insn_ready));

   // R8: phases never overlap
   p_phase_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rf_rd_en, rf_wr_en, done, illegal}));

   // R6: once writing starts, no further read of this operation
   p_no_read_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en |=> !rf_rd_en);

   // R8: the write phase is entered only from the read phase
   p_write_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rf_wr_en) |-> $past(rf_rd_en));

endmodule

bind pme_engine pme_checker u_pme_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_valid (insn_valid),
   .insn_ready (insn_ready),
   .rf_rd_en   (rf_rd_en),
   .rf_wr_en   (rf_wr_en),
   .done       (done),
   .illegal    (illegal)
);

// File: tb/pme_engine_bench.sv
`timescale 1ns/1ps
module pme_engine_bench;

   localparam int DW   = 32;
   localparam int NVEC = 17;

   // {legal, word}
   localparam logic [64:0] VEC [NVEC] = '{
      65'h1_24000009_00050905,  // 0  swap r5 <-> r9
      65'h1_24000020_00211110,  // 1  swizzle, disjoint
      65'h1_24000140_40070341,  // 2  gather overlapping own sources
      65'h1_240001FE_04030201,  // 3  gather wrapping past 255
      65'h1_24000231_60305030,  // 4  scatter
      65'h1_24000270_737271FD,  // 5  scatter reading past 255
      65'h1_24000290_90919080,  // 6  scatter, repeated destination
      65'h1_2400000A_000A0605,  // 7  swizzle, same destination twice
      65'h1_3C847011_00121112,  // 8  ignored bits set, swap
      65'h0_44000009_00050905,  // 9  wrong class
      65'h0_24000409_00050905,  // 10 bit 42 set
      65'h0_24000309_00050905,  // 11 sub-op 11
      65'h0_24000009_01050905,  // 12 swizzle pad non-zero
      65'h0_24000809_00050905,  // 13 bit 43 set
      65'h0_24020009_00050905,  // 14 bit 49 set
      65'h0_24200009_00050905,  // 15 bits 54:53 = 01
      65'h0_26000009_00050905   // 16 bits 58:57 = 11
   };

   function automatic string vec_tag(input int i);
      case (i)
         0:       return "R6";
         1:       return "R3";
         2:       return "R4";
         3, 5:    return "R10";
         4:       return "R5";
         6, 7:    return "R9";
         8, 9, 10, 16: return "R1";
         11:      return "R2";
         12:      return "R3";
         default: return "R7";
      endcase
   endfunction

   logic          clk = 1'b0;
   logic          rst_n;
   logic          insn_valid;
   logic [63:0]   insn_word;
   logic          insn_ready;
   logic          rf_rd_en;
   logic [7:0]    rf_rd_addr;
   logic [DW-1:0] rf_rd_data;
   logic          rf_wr_en;
   logic [7:0]    rf_wr_addr;
   logic [DW-1:0] rf_wr_data;
   logic          done;
   logic          illegal;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [DW-1:0] rf  [256];
   logic [DW-1:0] exp_rf [256];

   always #5 clk = ~clk;

   pme_engine #(.DATA_W(DW)) u_pme_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .insn_valid (insn_valid),
      .insn_word  (insn_word),
      .insn_ready (insn_ready),
      .rf_rd_en   (rf_rd_en),
      .rf_rd_addr (rf_rd_addr),
      .rf_rd_data (rf_rd_data),
      .rf_wr_en   (rf_wr_en),
      .rf_wr_addr (rf_wr_addr),
      .rf_wr_data (rf_wr_data),
      .done       (done),
      .illegal    (illegal)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) rf[i] <= 32'hA500_0000 + 32'(i * 3);
      end else if (rf_wr_en) begin
         rf[rf_wr_addr] <= rf_wr_data;
      end
   end
   assign rf_rd_data = rf[rf_rd_addr];

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 50000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run still going, actual %0d cycles, expected fewer", cycles);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Expected register file after one word, from the requirements only.
   task automatic build_expect(input logic [63:0] w, input bit legal);
      logic [7:0]    s [4];
      logic [7:0]    d [4];
      logic [DW-1:0] v [4];
      int            n;
      for (int i = 0; i < 256; i++) exp_rf[i] = rf[i];
      if (!legal) return;
      case (w[41:40])
         2'b00: begin
            n = 2;
            s[0] = w[7:0];   d[0] = w[39:32];
            s[1] = w[15:8];  d[1] = w[23:16];
         end
         2'b01: begin
            n = 4;
            s[0] = w[7:0];  s[1] = w[15:8]; s[2] = w[23:16]; s[3] = w[31:24];
            for (int k = 0; k < 4; k++) d[k] = w[39:32] + 8'(k);
         end
         default: begin
            n = 4;
            for (int k = 0; k < 4; k++) s[k] = w[7:0] + 8'(k);
            d[0] = w[39:32]; d[1] = w[15:8]; d[2] = w[23:16]; d[3] = w[31:24];
         end
      endcase
      for (int k = 0; k < n; k++) v[k] = rf[s[k]];
      for (int k = 0; k < n; k++) exp_rf[d[k]] = v[k];
   endtask

   task automatic compare_rf(input string req);
      int bad   = 0;
      int first = -1;
      for (int i = 0; i < 256; i++) begin
         if (rf[i] !== exp_rf[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      end
      if (first < 0) first = 0;
      chk(bad == 0, req, $sformatf("register file, first bad index %0d", first),
          longint'(rf[first]), longint'(exp_rf[first]));
   endtask

   task automatic run_vec(input logic [63:0] w, input bit legal, input string req);
      int n       = (w[41:40] == 2'b00) ? 2 : 4;
      int cyc     = 1;
      int wr_cnt  = 0;
      int rdy_hi  = 0;
      bit saw_done = 0;
      bit saw_ill  = 0;
      build_expect(w, legal);
      @(negedge clk);
      insn_word  = w;
      insn_valid = 1'b1;
      @(negedge clk);
      insn_valid = 1'b0;
      while (cyc < 40) begin
         if (rf_wr_en)   wr_cnt++;
         if (insn_ready) rdy_hi++;
         if (done)    begin saw_done = 1; break; end
         if (illegal) begin saw_ill  = 1; break; end
         @(negedge clk);
         cyc++;
      end
      chk(saw_done == legal && saw_ill == !legal, req, "done/illegal outcome",
          {saw_done, saw_ill}, {legal, !legal});
      chk(cyc == (legal ? 2 * n + 1 : 1), legal ? "R8" : "R1", "terminal pulse cycle",
          cyc, legal ? 2 * n + 1 : 1);
      chk(wr_cnt == (legal ? n : 0), legal ? "R8" : "R1", "write cycles",
          wr_cnt, legal ? n : 0);
      chk(rdy_hi == 0, "R11", "ready while busy", rdy_hi, 0);
      @(negedge clk);
      chk(insn_ready == 1'b1 && !done && !illegal, "R11", "ready after pulse",
          {insn_ready, done, illegal}, 3'b100);
      compare_rf(req);
   endtask

   initial begin
      rst_n      = 1'b0;
      insn_valid = 1'b0;
      insn_word  = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: reset state
      chk(insn_ready && !rf_rd_en && !rf_wr_en && !done && !illegal, "R11",
          "reset state", {insn_ready, rf_rd_en, rf_wr_en, done, illegal}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         run_vec(VEC[i][63:0], VEC[i][64], vec_tag(i));
      end

      // R6: a second swap of the same pair restores the first order
      run_vec(64'h24000009_00050905, 1'b1, "R6");

      // R11: word held while busy, then changed, is not taken again
      begin
         int wr_cnt = 0;
         int cyc    = 0;
         build_expect(64'h24000033_00343334, 1'b1);
         @(negedge clk);
         insn_word  = 64'h24000033_00343334;
         insn_valid = 1'b1;
         @(negedge clk);
         insn_word  = 64'h24000150_04030201;
         repeat (3) begin
            if (rf_wr_en) wr_cnt++;
            @(negedge clk);
         end
         insn_valid = 1'b0;
         while (!done && cyc < 20) begin
            if (rf_wr_en) wr_cnt++;
            @(negedge clk);
            cyc++;
         end
         @(negedge clk);
         chk(wr_cnt == 2, "R11", "writes with word held while busy", wr_cnt, 2);
         compare_rf("R11");
      end

      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

endmodule